// File: doc/BRIEF.md
# Single-Wire LED Data Stream Receiver

The block turns one single-wire, pulse-width-coded LED data stream into a sequence of bytes. The data line is asynchronous to the system clock. It passes through a two-flop synchronizer, and rising edges are found on the synchronized copy. Every bit begins with a rising edge. The receiver samples the line a fixed number of clock ticks after that edge. A line that is still high at the sample point decodes as a one, and a line that has already fallen decodes as a zero.

Bits are assembled most significant first. Each complete group of eight is presented as a byte with a one-cycle valid strobe. A long low period on the line marks the end of a frame. The receiver then raises a one-cycle frame-done pulse and drops any byte it has only partly assembled. The receiver does not accept data straight after reset or after a frame end. It first requires the line to stay low for a continuous quiet interval, so it can never lock on to a frame that is already in progress.

The controller has five states:
- QUIET counts continuous low time. A high level restarts the count, and a complete interval moves the controller to ARMED.
- ARMED waits, with no time limit, for a rising edge. That edge moves it to DELAY.
- DELAY counts the sample delay. It then samples one bit and moves to WAITLOW.
- WAITLOW waits for the line to fall and then moves to GAP.
- GAP counts low time. A rising edge goes back to DELAY. A full reset interval raises frame-done and returns to QUIET.

All intervals are parameters given in clock ticks. The defaults are 1280 quiet ticks, 6400 reset ticks and a sample delay of 63 ticks, which suit a 125 MHz clock.

Top module: `ledline_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `byte_valid` and `frame_done` are 0 and `byte_data` is 0.
- R2: Capture arms only after the synchronized line has been low for QUIET_TICKS consecutive cycles. Any high level during that interval restarts the count. Pulses that arrive before the receiver is armed produce no byte and no frame-done.
- R3: Once armed, each rising edge starts a bit. The line is sampled SAMPLE_TICKS cycles after the edge is seen, and it decodes as 1 when the line is high and as 0 when it is low.
- R4: Bits are shifted in MSB first, so the first bit of a byte is `byte_data[7]`. When the eighth bit arrives, `byte_valid` is high for exactly one cycle with the byte on `byte_data`.
- R5: After a bit, if the line stays low for RESET_TICKS cycles with no new rising edge, `frame_done` pulses high for one cycle.
- R6: At frame end, a partly assembled byte is discarded and the bit count is cleared. The first byte of the next frame is built only from that frame's bits.
- R7: After frame end, the receiver returns to the quiet check. A stream that starts before a fresh quiet interval has passed is ignored.
- R8: `byte_valid` and `frame_done` are never high in the same cycle, and `byte_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous serial data line |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte, first received bit in bit 7 |
| frame_done | output | 1 | One-cycle pulse at the end-of-frame gap |

## Verification
The assertions assume that every high pulse on the line lasts long enough to be seen after synchronization. They also assume that the sample delay is shorter than a bit period, so that a new rising edge never arrives while a bit is still being timed. The stimulus drives the line only at the falling clock edge. It uses a fixed bit period with high times placed well before and well after the sample point. Every gap inside a frame is far shorter than both the quiet interval and the reset interval, and every gap between frames is far longer than the reset interval.

// File: rtl/ledline_rx_pkg.sv
package ledline_rx_pkg;
    typedef enum logic [2:0] {
        ST_QUIET   = 3'd0,
        ST_ARMED   = 3'd1,
        ST_DELAY   = 3'd2,
        ST_WAITLOW = 3'd3,
        ST_GAP     = 3'd4
    } rx_state_t;
endpackage

// File: rtl/ledline_rx_sync.sv
module ledline_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain   <= '0;
            level_d <= 1'b0;
        end else begin
            chain   <= {chain[STAGES-2:0], async_in};
            level_d <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~level_d;
endmodule

// File: rtl/ledline_rx_fsm.sv
module ledline_rx_fsm
    import ledline_rx_pkg::*;
#(
    parameter int QUIET_TICKS  = 1280,
    parameter int RESET_TICKS  = 6400,
    parameter int SAMPLE_TICKS = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic line_rise,
    output logic bit_stb,
    output logic bit_val,
    output logic frame_done
);
    localparam int MAXT = (QUIET_TICKS > RESET_TICKS) ?
                          ((QUIET_TICKS > SAMPLE_TICKS) ? QUIET_TICKS : SAMPLE_TICKS) :
                          ((RESET_TICKS > SAMPLE_TICKS) ? RESET_TICKS : SAMPLE_TICKS);
    localparam int CW = $clog2(MAXT + 1);

    rx_state_t     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          stb_n, val_n, done_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt + CW'(1);
        stb_n   = 1'b0;
        val_n   = 1'b0;
        done_n  = 1'b0;
        unique case (state)
            ST_QUIET: begin
                if (line_s) begin
                    cnt_n = '0;
                end else if (cnt == CW'(QUIET_TICKS - 1)) begin
                    state_n = ST_ARMED;
                    cnt_n   = '0;
                end
            end
            ST_ARMED: begin
                cnt_n = '0;
                if (line_rise) state_n = ST_DELAY;
            end
            ST_DELAY: begin
                if (cnt == CW'(SAMPLE_TICKS - 1)) begin
                    stb_n   = 1'b1;
                    val_n   = line_s;
                    state_n = ST_WAITLOW;
                    cnt_n   = '0;
                end
            end
            ST_WAITLOW: begin
                cnt_n = '0;
                if (!line_s) begin
                    state_n = ST_GAP;
                    cnt_n   = CW'(1);
                end
            end
            ST_GAP: begin
                if (line_rise) begin
                    state_n = ST_DELAY;
                    cnt_n   = '0;
                end else if (cnt == CW'(RESET_TICKS - 1)) begin
                    done_n  = 1'b1;
                    state_n = ST_QUIET;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_QUIET;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_QUIET;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_stb    <= 1'b0;
            bit_val    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            bit_stb    <= stb_n;
            bit_val    <= val_n;
            frame_done <= done_n;
        end
    end

    // R3: bit timing never overruns the sample delay
    a_r3_sample_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY) |-> (cnt < CW'(SAMPLE_TICKS)));

    // R2: arming happens only out of a low line
    a_r2_arm_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && $past(state) == ST_QUIET) |-> !$past(line_s));

    // R5: frame end is declared only while the line is low
    a_r5_done_low: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !$past(line_s));

    // R7: after frame end the controller is back in the quiet check
    a_r7_requiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (state == ST_QUIET));
endmodule

// File: rtl/ledline_rx_shift.sv
module ledline_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              clear,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int BC_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sreg;
    logic [BC_W-1:0]   bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg       <= '0;
            bcnt       <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (clear) begin
                sreg <= '0;
                bcnt <= '0;
            end else if (bit_stb) begin
                sreg <= {sreg[BYTE_W-2:0], bit_val};
                if (bcnt == BC_W'(BYTE_W - 1)) begin
                    bcnt       <= '0;
                    byte_valid <= 1'b1;
                    byte_data  <= {sreg[BYTE_W-2:0], bit_val};
                end else begin
                    bcnt <= bcnt + BC_W'(1);
                end
            end
        end
    end

    // R4: bytes are separated by at least one idle cycle
    a_r4_byte_gap: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R6: a cleared frame restarts the bit count
    a_r6_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bcnt == '0));
endmodule

// File: rtl/ledline_rx.sv
module ledline_rx #(
    parameter int QUIET_TICKS  = 1280,
    parameter int RESET_TICKS  = 6400,
    parameter int SAMPLE_TICKS = 63
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_done
);
    logic line_s, line_rise, bit_stb, bit_val;

    ledline_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(line_in),
        .level(line_s), .rise(line_rise)
    );

    ledline_rx_fsm #(
        .QUIET_TICKS(QUIET_TICKS), .RESET_TICKS(RESET_TICKS),
        .SAMPLE_TICKS(SAMPLE_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .line_rise(line_rise),
        .bit_stb(bit_stb), .bit_val(bit_val), .frame_done(frame_done)
    );

    ledline_rx_shift #(.BYTE_W(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .clear(frame_done), .byte_valid(byte_valid), .byte_data(byte_data)
    );

    // R8: byte strobe and frame pulse never coincide
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && frame_done));
endmodule

// File: tb/sim_ledline_rx.sv
module sim_ledline_rx;
    localparam int QT = 64;
    localparam int RT = 300;
    localparam int ST = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       byte_valid, frame_done;
    logic [7:0] byte_data;

    int checks = 0;
    int failures = 0;
    int frames = 0;
    logic [7:0] expq[$];
    logic       expect_on = 1'b1;
    logic       prev_bv = 1'b0;

    always #2 clk = ~clk;

    ledline_rx #(.QUIET_TICKS(QT), .RESET_TICKS(RT), .SAMPLE_TICKS(ST)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_done(frame_done)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        int hi;
        hi = b ? 32 : 8;
        line_in = 1'b1;
        idle(hi);
        line_in = 1'b0;
        idle(48 - hi);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic keep);
        if (keep) expq.push_back(v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_done) frames++;
            if (byte_valid && frame_done)
                check(1'b0, "R8 overlap", 1, 0);
            if (byte_valid && prev_bv)
                check(1'b0, "R8 back-to-back", 1, 0);
            if (byte_valid) begin
                if (expq.size() == 0)
                    check(1'b0, "R2/R7 unexpected byte", int'(byte_data), 0);
                else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    check(byte_data == e, "R3/R4 byte value", int'(byte_data), int'(e));
                end
            end
            prev_bv = byte_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(5);
        check(!byte_valid && !frame_done && byte_data == 8'h00, "R1 in reset",
              {byte_valid, frame_done, byte_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!byte_valid && !frame_done && byte_data == 8'h00, "R1 after reset",
              {byte_valid, frame_done, byte_data}, 0);

        // R2: stream starts before any quiet interval; must be ignored
        idle(10);
        send_byte(8'hFF, 1'b0);
        send_byte(8'h00, 1'b0);
        idle(2 * RT);
        check(frames == 0, "R2 no frame before arming", frames, 0);
        check(expq.size() == 0, "R2 no bytes before arming", expq.size(), 0);

        // R3 R4 R5: normal frame
        send_byte(8'hA5, 1'b1);
        send_byte(8'h3C, 1'b1);
        send_byte(8'h81, 1'b1);
        idle(RT + 100);
        check(frames == 1, "R5 frame done count", frames, 1);
        check(expq.size() == 0, "R4 all bytes seen", expq.size(), 0);

        // R6: 12 bits then reset gap; partial nibble dropped
        send_byte(8'h5A, 1'b1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        idle(RT + 100);
        check(frames == 2, "R6 partial frame ended", frames, 2);
        send_byte(8'h0F, 1'b1);
        idle(RT + 100);
        check(frames == 3, "R6 next frame ended", frames, 3);
        check(expq.size() == 0, "R6 clean first byte", expq.size(), 0);

        // R7: stream right after frame end is ignored
        send_byte(8'h01, 1'b1);
        @(posedge frame_done);
        idle(5);
        send_byte(8'h77, 1'b0);
        idle(RT + 100);
        check(frames == 4, "R7 ignored stream gives no frame", frames, 4);
        check(expq.size() == 0, "R7 no stray bytes", expq.size(), 0);
        send_byte(8'h99, 1'b1);
        idle(RT + 100);
        check(frames == 5, "R7 recovers after quiet", frames, 5);
        check(expq.size() == 0, "R7 final byte seen", expq.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule